// File: doc/BRIEF.md
# Snooping MESI Coherence Controller

This block keeps the coherence state of a small direct-mapped write-back cache that holds one data word per line. Every line is in one of four states: Invalid, Shared, Exclusive or Modified. A local processor port issues reads and writes. The controller serves hits itself, and reaches a shared snooped bus through a request/grant handshake when it needs a fill, an ownership transfer, an invalidation or a write-back. The memory behind the bus always answers in the cycle of the grant.

Other requesters' transactions arrive on a snoop port. Each one is matched against the tag of the indexed line. On a match the controller reports that it holds a copy, supplies dirty data when it must, and demotes or kills the line. A state change that needs the bus waits in a pending phase until the grant arrives. If a competing invalidation removes the line while an upgrade is waiting, the upgrade is turned into a read-for-ownership.

The address is split into an index in the low `$clog2(LINES)` bits and a tag in the remaining upper bits. Bus and snoop command codes are: 0 none, 1 read, 2 read-for-ownership (bus write), 3 upgrade (invalidate), 4 write-back.

Top module: `mesi_snoop_ctrl`

## Requirements
- R1: After reset every line is Invalid, cpu_done_o, bus_req_o and bus_valid_o are low, and a snooped read (code 1) to any address returns snp_shared_o=0 and snp_flush_o=0.
- R2: A local read miss with bus_shared_i low in the grant cycle issues a bus read (code 1) to the request address and leaves the line Exclusive, so a later write to it completes without any bus transaction.
- R3: A local read miss with bus_shared_i high in the grant cycle leaves the line Shared, so a later write to it issues an upgrade (code 3) before it completes.
- R4: A local read or write that hits an Exclusive or Modified line raises cpu_done_o one cycle after the accepting edge, with no bus request. A write to an Exclusive line moves it to Modified.
- R5: A snooped read (code 1) that hits a Modified line raises snp_flush_o and snp_shared_o in the same cycle, drives the line's data on snp_data_o, and moves the line to Shared.
- R6: A snooped read that hits an Exclusive line raises snp_shared_o with snp_flush_o low and moves the line to Shared.
- R7: A snooped read-for-ownership (code 2) or upgrade (code 3) that hits a valid line moves it to Invalid. If the line was Modified, snp_flush_o is high and snp_data_o carries its data in that cycle.
- R8: A local write miss issues a read-for-ownership (code 2) and leaves the line Modified, holding the written data.
- R9: A miss whose victim line is Modified first issues a write-back (code 4) carrying the victim's address and data, then the fill. A miss on a clean victim issues only the fill.
- R10: Once raised, bus_req_o stays high until a grant, and the access does not complete before the grant. bus_valid_o is high only in the grant cycle.
- R11: If a snooped upgrade invalidates the line while a local upgrade is waiting for the grant, the request is issued as a read-for-ownership (code 2) instead.
- R12: A snoop whose tag differs from that of the indexed line leaves outputs and line state unchanged.
- R13: A completed read returns the line's data on cpu_rdata_o when it hits, and on a miss the data the memory supplied during the grant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req_i | input | 1 | Local access request, held until completion |
| cpu_we_i | input | 1 | Local access is a write |
| cpu_addr_i | input | ADDR_W | Local word address |
| cpu_wdata_i | input | DATA_W | Local write data |
| cpu_done_o | output | 1 | One-cycle completion pulse |
| cpu_rdata_o | output | DATA_W | Read data, valid with cpu_done_o |
| bus_req_o | output | 1 | Request for the shared bus |
| bus_gnt_i | input | 1 | Bus grant, one cycle |
| bus_valid_o | output | 1 | Transaction placed on the bus this cycle |
| bus_cmd_o | output | 3 | Bus command code |
| bus_addr_o | output | ADDR_W | Bus address |
| bus_wdata_o | output | DATA_W | Write-back data |
| bus_shared_i | input | 1 | Another cache holds the block |
| mem_rdata_i | input | DATA_W | Memory fill data |
| snp_valid_i | input | 1 | Snooped transaction present |
| snp_cmd_i | input | 3 | Snooped command code |
| snp_addr_i | input | ADDR_W | Snooped address |
| snp_shared_o | output | 1 | This cache holds the snooped block |
| snp_flush_o | output | 1 | This cache supplies dirty data |
| snp_data_o | output | DATA_W | Supplied dirty data |

## Verification
A hit completes one edge after it is accepted. A bus transaction appears in its grant cycle and its completion follows one cycle later. Snoop responses are valid combinationally in the snoop cycle, and line state changes at the next edge. Inputs change just after a rising edge and every output is sampled at the falling edge. A scoreboard holds the expected bus transactions and completions in order, so an extra bus transaction on a hit or a wrong command code shows up as a mismatch. Line states are observed indirectly, through the bus traffic or snoop response that the next access produces.

// File: rtl/mesi_pkg.sv
package mesi_pkg;

    typedef enum logic [1:0] {
        LS_INV = 2'd0,
        LS_SHR = 2'd1,
        LS_EXC = 2'd2,
        LS_MOD = 2'd3
    } line_state_e;

    localparam logic [2:0] BC_NONE  = 3'd0;
    localparam logic [2:0] BC_READ  = 3'd1;
    localparam logic [2:0] BC_RFO   = 3'd2;
    localparam logic [2:0] BC_UPGR  = 3'd3;
    localparam logic [2:0] BC_WBACK = 3'd4;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_EVICT = 2'd1,
        PH_FILL  = 2'd2,
        PH_UPGR  = 2'd3
    } phase_e;

endpackage

// File: rtl/mesi_line_store.sv
module mesi_line_store
    import mesi_pkg::*;
#(
    parameter int LINES  = 4,
    parameter int TAG_W  = 10,
    parameter int DATA_W = 32,
    localparam int IDX_W = $clog2(LINES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  loc_idx,
    output line_state_e       loc_st,
    output logic [TAG_W-1:0]  loc_tag,
    output logic [DATA_W-1:0] loc_data,
    input  logic [IDX_W-1:0]  snp_idx,
    output line_state_e       snp_st,
    output logic [TAG_W-1:0]  snp_tag,
    output logic [DATA_W-1:0] snp_data,
    input  logic              loc_wr,
    input  line_state_e       loc_wr_st,
    input  logic [TAG_W-1:0]  loc_wr_tag,
    input  logic              loc_wr_data_en,
    input  logic [DATA_W-1:0] loc_wr_data,
    input  logic              snp_wr,
    input  line_state_e       snp_wr_st
);

    line_state_e       st_q   [LINES];
    line_state_e       st_d   [LINES];
    logic [TAG_W-1:0]  tag_q  [LINES];
    logic [TAG_W-1:0]  tag_d  [LINES];
    logic [DATA_W-1:0] data_q [LINES];
    logic [DATA_W-1:0] data_d [LINES];

    // Next-state arrays: the local port first, then snoop updates on top.
    always_comb begin
        st_d   = st_q;
        tag_d  = tag_q;
        data_d = data_q;
        if (loc_wr) begin
            st_d[loc_idx]  = loc_wr_st;
            tag_d[loc_idx] = loc_wr_tag;
            if (loc_wr_data_en) begin
                data_d[loc_idx] = loc_wr_data;
            end
        end
        if (snp_wr) begin
            st_d[snp_idx] = snp_wr_st;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < LINES; i++) begin
                st_q[i]   <= LS_INV;
                tag_q[i]  <= '0;
                data_q[i] <= '0;
            end
        end else begin
            st_q   <= st_d;
            tag_q  <= tag_d;
            data_q <= data_d;
        end
    end

    assign loc_st   = st_q[loc_idx];
    assign loc_tag  = tag_q[loc_idx];
    assign loc_data = data_q[loc_idx];
    assign snp_st   = st_q[snp_idx];
    assign snp_tag  = tag_q[snp_idx];
    assign snp_data = data_q[snp_idx];

    // A snoop kill must leave the line Invalid on the next cycle.
    assert_snoop_kill_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (snp_wr && snp_wr_st == LS_INV && !loc_wr) |=> st_q[$past(snp_idx)] == LS_INV);

endmodule

// File: rtl/mesi_snoop_match.sv
module mesi_snoop_match
    import mesi_pkg::*;
#(
    parameter int TAG_W  = 10,
    parameter int DATA_W = 32
) (
    input  logic              snp_valid,
    input  logic [2:0]        snp_cmd,
    input  logic [TAG_W-1:0]  snp_tag,
    input  line_state_e       line_st,
    input  logic [TAG_W-1:0]  line_tag,
    input  logic [DATA_W-1:0] line_data,
    output logic              shared_o,
    output logic              flush_o,
    output logic [DATA_W-1:0] data_o,
    output logic              upd_en,
    output line_state_e       upd_st
);

    logic hit;

    always_comb begin
        hit      = snp_valid && (line_st != LS_INV) && (line_tag == snp_tag);
        shared_o = 1'b0;
        flush_o  = 1'b0;
        upd_en   = 1'b0;
        upd_st   = line_st;
        if (hit) begin
            case (snp_cmd)
                BC_READ: begin
                    shared_o = 1'b1;
                    flush_o  = (line_st == LS_MOD);
                    if (line_st == LS_MOD || line_st == LS_EXC) begin
                        upd_en = 1'b1;
                        upd_st = LS_SHR;
                    end
                end
                BC_RFO, BC_UPGR: begin
                    flush_o = (line_st == LS_MOD);
                    upd_en  = 1'b1;
                    upd_st  = LS_INV;
                end
                default: ;
            endcase
        end
        data_o = flush_o ? line_data : '0;
    end

endmodule

// File: rtl/mesi_local_seq.sv
module mesi_local_seq
    import mesi_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 32,
    parameter int IDX_W  = 2,
    localparam int TAG_W = ADDR_W - IDX_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    input  logic              snp_busy,
    input  logic              bus_gnt,
    input  logic              bus_shared,
    input  logic [DATA_W-1:0] mem_rdata,
    input  line_state_e       line_st,
    input  logic [TAG_W-1:0]  line_tag,
    input  logic [DATA_W-1:0] line_data,
    output logic              cpu_done,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              bus_req,
    output logic [2:0]        bus_cmd,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_wdata,
    output logic              bus_valid,
    output logic              wr_en,
    output line_state_e       wr_st,
    output logic [TAG_W-1:0]  wr_tag,
    output logic              wr_data_en,
    output logic [DATA_W-1:0] wr_data
);

    typedef struct packed {
        phase_e            ph;
        logic              done;
        logic [DATA_W-1:0] rdata;
    } seq_t;

    seq_t cur_q, nxt_d;

    logic [IDX_W-1:0] req_idx;
    logic [TAG_W-1:0] req_tag;
    logic             tag_hit;
    logic             still_shr;
    logic [2:0]       fill_cmd;
    logic             fill_go;

    assign req_idx   = cpu_addr[IDX_W-1:0];
    assign req_tag   = cpu_addr[ADDR_W-1:IDX_W];
    assign tag_hit   = (line_st != LS_INV) && (line_tag == req_tag);
    assign still_shr = (line_st == LS_SHR) && (line_tag == req_tag);
    assign fill_cmd  = cpu_we ? BC_RFO : BC_READ;

    always_comb begin
        nxt_d      = cur_q;
        nxt_d.done = 1'b0;
        bus_req    = 1'b0;
        bus_cmd    = BC_NONE;
        bus_addr   = cpu_addr;
        bus_wdata  = '0;
        wr_en      = 1'b0;
        wr_st      = line_st;
        wr_tag     = req_tag;
        wr_data_en = 1'b0;
        wr_data    = cpu_wdata;
        fill_go    = 1'b0;

        case (cur_q.ph)
            PH_IDLE: begin
                if (cpu_req && !cur_q.done && !snp_busy) begin
                    if (tag_hit && !cpu_we) begin
                        nxt_d.done  = 1'b1;
                        nxt_d.rdata = line_data;
                    end else if (tag_hit && line_st != LS_SHR) begin
                        wr_en      = 1'b1;
                        wr_st      = LS_MOD;
                        wr_data_en = 1'b1;
                        nxt_d.done = 1'b1;
                    end else if (tag_hit) begin
                        nxt_d.ph = PH_UPGR;
                    end else if (line_st == LS_MOD) begin
                        nxt_d.ph = PH_EVICT;
                    end else begin
                        nxt_d.ph = PH_FILL;
                    end
                end
            end
            PH_EVICT: begin
                bus_req = 1'b1;
                if (line_st == LS_MOD) begin
                    bus_cmd   = BC_WBACK;
                    bus_addr  = {line_tag, req_idx};
                    bus_wdata = line_data;
                    if (bus_gnt) begin
                        wr_en    = 1'b1;
                        wr_st    = LS_INV;
                        wr_tag   = line_tag;
                        nxt_d.ph = PH_FILL;
                    end
                end else begin
                    bus_cmd = fill_cmd;
                    fill_go = bus_gnt;
                end
            end
            PH_FILL: begin
                bus_req = 1'b1;
                bus_cmd = fill_cmd;
                fill_go = bus_gnt;
            end
            PH_UPGR: begin
                bus_req = 1'b1;
                if (still_shr) begin
                    bus_cmd = BC_UPGR;
                    if (bus_gnt) begin
                        wr_en      = 1'b1;
                        wr_st      = LS_MOD;
                        wr_data_en = 1'b1;
                        nxt_d.done = 1'b1;
                        nxt_d.ph   = PH_IDLE;
                    end
                end else begin
                    bus_cmd = BC_RFO;
                    fill_go = bus_gnt;
                end
            end
            default: nxt_d.ph = PH_IDLE;
        endcase

        if (fill_go) begin
            wr_en       = 1'b1;
            wr_tag      = req_tag;
            wr_data_en  = 1'b1;
            wr_data     = cpu_we ? cpu_wdata : mem_rdata;
            wr_st       = cpu_we ? LS_MOD : (bus_shared ? LS_SHR : LS_EXC);
            nxt_d.done  = 1'b1;
            nxt_d.rdata = mem_rdata;
            nxt_d.ph    = PH_IDLE;
        end

        bus_valid = bus_req && bus_gnt;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q <= '{ph: PH_IDLE, done: 1'b0, rdata: '0};
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign cpu_done  = cur_q.done;
    assign cpu_rdata = cur_q.rdata;

    // A bus request is never withdrawn before its grant.
    assert_req_held_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_gnt) |=> bus_req);

    // A granted write-back is always followed by the fill request.
    assert_wback_then_fill_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && bus_cmd == BC_WBACK) |=> (bus_req && !cpu_done));

endmodule

// File: rtl/mesi_snoop_ctrl.sv
module mesi_snoop_ctrl
    import mesi_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 32,
    parameter int LINES  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req_i,
    input  logic              cpu_we_i,
    input  logic [ADDR_W-1:0] cpu_addr_i,
    input  logic [DATA_W-1:0] cpu_wdata_i,
    output logic              cpu_done_o,
    output logic [DATA_W-1:0] cpu_rdata_o,
    output logic              bus_req_o,
    input  logic              bus_gnt_i,
    output logic              bus_valid_o,
    output logic [2:0]        bus_cmd_o,
    output logic [ADDR_W-1:0] bus_addr_o,
    output logic [DATA_W-1:0] bus_wdata_o,
    input  logic              bus_shared_i,
    input  logic [DATA_W-1:0] mem_rdata_i,
    input  logic              snp_valid_i,
    input  logic [2:0]        snp_cmd_i,
    input  logic [ADDR_W-1:0] snp_addr_i,
    output logic              snp_shared_o,
    output logic              snp_flush_o,
    output logic [DATA_W-1:0] snp_data_o
);

    localparam int IDX_W = $clog2(LINES);
    localparam int TAG_W = ADDR_W - IDX_W;

    line_state_e       loc_st, snp_st, loc_wr_st, snp_upd_st;
    logic [TAG_W-1:0]  loc_tag, snp_tag_line, loc_wr_tag;
    logic [DATA_W-1:0] loc_data, snp_line_data, loc_wr_data;
    logic              loc_wr, loc_wr_data_en, snp_upd_en;

    mesi_line_store #(
        .LINES (LINES),
        .TAG_W (TAG_W),
        .DATA_W(DATA_W)
    ) store_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .loc_idx       (cpu_addr_i[IDX_W-1:0]),
        .loc_st        (loc_st),
        .loc_tag       (loc_tag),
        .loc_data      (loc_data),
        .snp_idx       (snp_addr_i[IDX_W-1:0]),
        .snp_st        (snp_st),
        .snp_tag       (snp_tag_line),
        .snp_data      (snp_line_data),
        .loc_wr        (loc_wr),
        .loc_wr_st     (loc_wr_st),
        .loc_wr_tag    (loc_wr_tag),
        .loc_wr_data_en(loc_wr_data_en),
        .loc_wr_data   (loc_wr_data),
        .snp_wr        (snp_upd_en),
        .snp_wr_st     (snp_upd_st)
    );

    mesi_snoop_match #(
        .TAG_W (TAG_W),
        .DATA_W(DATA_W)
    ) match_i (
        .snp_valid(snp_valid_i),
        .snp_cmd  (snp_cmd_i),
        .snp_tag  (snp_addr_i[ADDR_W-1:IDX_W]),
        .line_st  (snp_st),
        .line_tag (snp_tag_line),
        .line_data(snp_line_data),
        .shared_o (snp_shared_o),
        .flush_o  (snp_flush_o),
        .data_o   (snp_data_o),
        .upd_en   (snp_upd_en),
        .upd_st   (snp_upd_st)
    );

    mesi_local_seq #(
        .ADDR_W(ADDR_W),
        .DATA_W(DATA_W),
        .IDX_W (IDX_W)
    ) seq_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .cpu_req   (cpu_req_i),
        .cpu_we    (cpu_we_i),
        .cpu_addr  (cpu_addr_i),
        .cpu_wdata (cpu_wdata_i),
        .snp_busy  (snp_valid_i),
        .bus_gnt   (bus_gnt_i),
        .bus_shared(bus_shared_i),
        .mem_rdata (mem_rdata_i),
        .line_st   (loc_st),
        .line_tag  (loc_tag),
        .line_data (loc_data),
        .cpu_done  (cpu_done_o),
        .cpu_rdata (cpu_rdata_o),
        .bus_req   (bus_req_o),
        .bus_cmd   (bus_cmd_o),
        .bus_addr  (bus_addr_o),
        .bus_wdata (bus_wdata_o),
        .bus_valid (bus_valid_o),
        .wr_en     (loc_wr),
        .wr_st     (loc_wr_st),
        .wr_tag    (loc_wr_tag),
        .wr_data_en(loc_wr_data_en),
        .wr_data   (loc_wr_data)
    );

    // Dirty data is only ever driven in answer to a real snooped command.
    assert_flush_on_snoop_R5: assert property (@(posedge clk) disable iff (!rst_n)
        snp_flush_o |-> (snp_valid_i && snp_cmd_i != BC_WBACK && snp_cmd_i != BC_NONE));

    // A granted read-for-ownership leaves the requested line Modified.
    assert_rfo_owns_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid_o && bus_cmd_o == BC_RFO) |=> (loc_st == LS_MOD));

endmodule

// File: tb/mesi_snoop_ctrl_tb_top.sv
module mesi_snoop_ctrl_tb_top;
    import mesi_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W = 12;
    localparam int DATA_W = 32;
    localparam int LINES  = 4;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cpu_req = 1'b0, cpu_we = 1'b0;
    logic [ADDR_W-1:0] cpu_addr = '0;
    logic [DATA_W-1:0] cpu_wdata = '0;
    logic              cpu_done;
    logic [DATA_W-1:0] cpu_rdata;
    logic              bus_req, bus_valid;
    logic              bus_gnt = 1'b0;
    logic [2:0]        bus_cmd;
    logic [ADDR_W-1:0] bus_addr;
    logic [DATA_W-1:0] bus_wdata;
    logic              bus_shared = 1'b0;
    logic [DATA_W-1:0] mem_rdata;
    logic              snp_valid = 1'b0;
    logic [2:0]        snp_cmd = '0;
    logic [ADDR_W-1:0] snp_addr = '0;
    logic              snp_shared, snp_flush;
    logic [DATA_W-1:0] snp_data;

    int n_chk = 0;
    int n_err = 0;
    int gnt_delay = 0;
    logic gnt_hold = 1'b0;
    int wait_cnt = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [DATA_W-1:0] memf(input logic [ADDR_W-1:0] a);
        return 32'hA500_0000 | {{(DATA_W-ADDR_W){1'b0}}, a};
    endfunction

    assign mem_rdata = memf(bus_addr);

    mesi_snoop_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LINES(LINES)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .cpu_req_i(cpu_req), .cpu_we_i(cpu_we), .cpu_addr_i(cpu_addr), .cpu_wdata_i(cpu_wdata),
        .cpu_done_o(cpu_done), .cpu_rdata_o(cpu_rdata),
        .bus_req_o(bus_req), .bus_gnt_i(bus_gnt), .bus_valid_o(bus_valid),
        .bus_cmd_o(bus_cmd), .bus_addr_o(bus_addr), .bus_wdata_o(bus_wdata),
        .bus_shared_i(bus_shared), .mem_rdata_i(mem_rdata),
        .snp_valid_i(snp_valid), .snp_cmd_i(snp_cmd), .snp_addr_i(snp_addr),
        .snp_shared_o(snp_shared), .snp_flush_o(snp_flush), .snp_data_o(snp_data)
    );

    task automatic chk(input string tag, input logic [DATA_W-1:0] act, input logic [DATA_W-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Scoreboard
    typedef struct packed {
        logic              is_done;
        logic [2:0]        cmd;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
        logic              data_chk;
    } exp_t;

    exp_t  exp_q[$];
    string tag_q[$];

    task automatic push_bus(input string tag, input logic [2:0] cmd, input logic [ADDR_W-1:0] addr,
                            input logic [DATA_W-1:0] data, input logic dchk);
        exp_q.push_back('{is_done: 1'b0, cmd: cmd, addr: addr, data: data, data_chk: dchk});
        tag_q.push_back(tag);
    endtask

    task automatic push_done(input string tag, input logic [DATA_W-1:0] data, input logic dchk);
        exp_q.push_back('{is_done: 1'b1, cmd: BC_NONE, addr: '0, data: data, data_chk: dchk});
        tag_q.push_back(tag);
    endtask

    task automatic sb_take(input logic is_done);
        exp_t  e;
        string t;
        if (exp_q.size() == 0) begin
            n_chk++;
            n_err++;
            $display("FAIL R10 unexpected event done=%0d actual cmd=%0d addr=%h expected none",
                     is_done, bus_cmd, bus_addr);
            return;
        end
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk({t, " kind"}, {{(DATA_W-1){1'b0}}, is_done}, {{(DATA_W-1){1'b0}}, e.is_done});
        if (!is_done) begin
            chk({t, " cmd"}, {{(DATA_W-3){1'b0}}, bus_cmd}, {{(DATA_W-3){1'b0}}, e.cmd});
            chk({t, " addr"}, {{(DATA_W-ADDR_W){1'b0}}, bus_addr}, {{(DATA_W-ADDR_W){1'b0}}, e.addr});
            if (e.data_chk) chk({t, " wdata"}, bus_wdata, e.data);
        end else if (e.data_chk) begin
            chk({t, " rdata"}, cpu_rdata, e.data);
        end
    endtask

    // Monitor
    always @(negedge clk) begin
        if (rst_n) begin
            if (bus_valid) sb_take(1'b0);
            if (cpu_done)  sb_take(1'b1);
        end
    end

    // Bus arbiter model
    always @(posedge clk) begin
        #1;
        if (!rst_n || bus_gnt) begin
            bus_gnt = 1'b0;
            wait_cnt = 0;
        end else if (bus_req && !gnt_hold) begin
            if (wait_cnt >= gnt_delay) begin
                bus_gnt = 1'b1;
                wait_cnt = 0;
            end else begin
                wait_cnt++;
            end
        end else begin
            wait_cnt = 0;
        end
    end

    task automatic cpu_op(input logic we, input logic [ADDR_W-1:0] addr, input logic [DATA_W-1:0] wd);
        @(posedge clk);
        #1;
        cpu_req = 1'b1;
        cpu_we = we;
        cpu_addr = addr;
        cpu_wdata = wd;
        @(negedge clk);
        while (cpu_done !== 1'b1) @(negedge clk);
        @(posedge clk);
        #1;
        cpu_req = 1'b0;
        cpu_we = 1'b0;
    endtask

    task automatic snoop(input string tag, input logic [2:0] cmd, input logic [ADDR_W-1:0] addr,
                         input logic esh, input logic efl, input logic [DATA_W-1:0] edata);
        @(posedge clk);
        #1;
        snp_valid = 1'b1;
        snp_cmd = cmd;
        snp_addr = addr;
        @(negedge clk);
        chk({tag, " snoop shared"}, {{(DATA_W-1){1'b0}}, snp_shared}, {{(DATA_W-1){1'b0}}, esh});
        chk({tag, " snoop flush"}, {{(DATA_W-1){1'b0}}, snp_flush}, {{(DATA_W-1){1'b0}}, efl});
        chk({tag, " snoop data"}, snp_data, edata);
        @(posedge clk);
        #1;
        snp_valid = 1'b0;
        snp_cmd = BC_NONE;
    endtask

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_chk++;
        n_err++;
        $display("FAIL watchdog actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk("R1 done", {31'b0, cpu_done}, 32'd0);
        chk("R1 req", {31'b0, bus_req}, 32'd0);
        chk("R1 valid", {31'b0, bus_valid}, 32'd0);
        snoop("R1", BC_READ, 12'h010, 1'b0, 1'b0, 32'h0);

        // R2 / R13: read miss, no sharers -> Exclusive
        push_bus("R2 read miss", BC_READ, 12'h010, '0, 1'b0);
        push_done("R13 fill data", memf(12'h010), 1'b1);
        cpu_op(1'b0, 12'h010, '0);
        // R4: write to Exclusive completes with no bus traffic
        push_done("R4 write hit E", '0, 1'b0);
        cpu_op(1'b1, 12'h010, 32'h1111_0001);
        push_done("R13 read hit", 32'h1111_0001, 1'b1);
        cpu_op(1'b0, 12'h010, '0);
        // R5: snooped read of Modified line
        snoop("R5", BC_READ, 12'h010, 1'b1, 1'b1, 32'h1111_0001);
        push_bus("R5 line now Shared", BC_UPGR, 12'h010, '0, 1'b0);
        push_done("R5 upgrade done", '0, 1'b0);
        cpu_op(1'b1, 12'h010, 32'h2222_0002);
        // R7: snooped RFO kills a Modified line with flush
        snoop("R7 rfo", BC_RFO, 12'h010, 1'b0, 1'b1, 32'h2222_0002);
        snoop("R7 gone", BC_READ, 12'h010, 1'b0, 1'b0, 32'h0);
        push_bus("R7 re-read misses", BC_READ, 12'h010, '0, 1'b0);
        push_done("R7 re-read data", memf(12'h010), 1'b1);
        cpu_op(1'b0, 12'h010, '0);

        // R3: read miss with sharers -> Shared
        bus_shared = 1'b1;
        push_bus("R3 read miss", BC_READ, 12'h021, '0, 1'b0);
        push_done("R3 data", memf(12'h021), 1'b1);
        cpu_op(1'b0, 12'h021, '0);
        bus_shared = 1'b0;
        push_bus("R3 upgrade", BC_UPGR, 12'h021, '0, 1'b0);
        push_done("R3 write done", '0, 1'b0);
        cpu_op(1'b1, 12'h021, 32'h3333_0003);

        // R6: snooped read of Exclusive line
        push_bus("R6 fill", BC_READ, 12'h012, '0, 1'b0);
        push_done("R6 fill done", memf(12'h012), 1'b1);
        cpu_op(1'b0, 12'h012, '0);
        snoop("R6", BC_READ, 12'h012, 1'b1, 1'b0, 32'h0);
        push_bus("R6 line now Shared", BC_UPGR, 12'h012, '0, 1'b0);
        push_done("R6 write done", '0, 1'b0);
        cpu_op(1'b1, 12'h012, 32'h4444_0004);

        // R12: tag mismatch snoop has no effect
        snoop("R12", BC_READ, 12'h052, 1'b0, 1'b0, 32'h0);
        snoop("R12 rfo", BC_RFO, 12'h052, 1'b0, 1'b0, 32'h0);
        push_done("R12 line intact", 32'h4444_0004, 1'b1);
        cpu_op(1'b0, 12'h012, '0);

        // R8: write miss -> RFO, Modified
        push_bus("R8 rfo", BC_RFO, 12'h033, '0, 1'b0);
        push_done("R8 done", '0, 1'b0);
        cpu_op(1'b1, 12'h033, 32'h5555_0005);
        snoop("R8 modified", BC_READ, 12'h033, 1'b1, 1'b1, 32'h5555_0005);

        // R9: dirty victim write-back, then clean victim
        push_bus("R9 upgrade", BC_UPGR, 12'h033, '0, 1'b0);
        push_done("R9 upgrade done", '0, 1'b0);
        cpu_op(1'b1, 12'h033, 32'h6666_0006);
        push_bus("R9 write-back", BC_WBACK, 12'h033, 32'h6666_0006, 1'b1);
        push_bus("R9 fill after wb", BC_READ, 12'h073, '0, 1'b0);
        push_done("R9 fill data", memf(12'h073), 1'b1);
        cpu_op(1'b0, 12'h073, '0);
        push_bus("R9 clean victim fill only", BC_READ, 12'h0B3, '0, 1'b0);
        push_done("R9 clean data", memf(12'h0B3), 1'b1);
        cpu_op(1'b0, 12'h0B3, '0);

        // R10: delayed grant
        gnt_delay = 6;
        push_bus("R10 delayed read", BC_READ, 12'h0F0, '0, 1'b0);
        push_done("R10 done after grant", memf(12'h0F0), 1'b1);
        fork
            cpu_op(1'b0, 12'h0F0, '0);
            begin
                repeat (4) @(negedge clk);
                chk("R10 req held", {31'b0, bus_req}, 32'd1);
                chk("R10 not done", {31'b0, cpu_done}, 32'd0);
                chk("R10 no valid", {31'b0, bus_valid}, 32'd0);
            end
        join
        gnt_delay = 0;

        // R11: pending upgrade converted to RFO
        snoop("R11 demote", BC_READ, 12'h021, 1'b1, 1'b1, 32'h3333_0003);
        gnt_hold = 1'b1;
        push_bus("R11 converted to rfo", BC_RFO, 12'h021, '0, 1'b0);
        push_done("R11 done", '0, 1'b0);
        fork
            cpu_op(1'b1, 12'h021, 32'h7777_0007);
            begin
                repeat (3) @(negedge clk);
                snoop("R11 competing upgrade", BC_UPGR, 12'h021, 1'b0, 1'b0, 32'h0);
                gnt_hold = 1'b0;
            end
        join
        snoop("R11 owned", BC_READ, 12'h021, 1'b1, 1'b1, 32'h7777_0007);

        repeat (2) @(negedge clk);
        chk("R10 scoreboard drained", exp_q.size(), 32'd0);
        finish_run();
    end

endmodule